// File: doc/BRIEF.md
# Processor Subsystem Power-Up Sequencer

This block brings a processor subsystem from a powered-off state to running, and back, by stepping through a fixed, timed list of control writes. It owns three control outputs: a reset group (stop, core reset, bus reset), a power control word (headswitch, regulator bypass, three clamps and two memory wake bits), and a memory power word with one enable bit per bank. Each write is applied on a microsecond tick and held for at least one tick before the next write. This spacing gives the headswitch time to settle, and the banks are turned on one at a time so that inrush current stays low.

Before the headswitch is enabled, the sequencer turns on a branch clock and polls its clock-off status on each tick. There is a limit on the number of polls, and a clock that never comes up ends the attempt with an error. The order in which banks are enabled is fixed at build time by a parameter: either a plain descending sweep, or a descending sweep of the upper banks followed by an ascending sweep of the lowest ones. A matching power-down request takes the subsystem back down in its own safe order. Each completed sequence gives a one-cycle done pulse. While a sequence runs, new requests are dropped.

Top module: `pss_power_seq`

## Requirements
- R1: After reset the outputs are: rst_ctl_o = 3'b111 (bit 0 stop, bit 1 core reset, bit 2 bus reset); pwr_ctl_o = 7'h1C (bit 0 headswitch, bit 1 regulator bypass, bit 2 memory clamp, bit 3 word-line clamp, bit 4 IO clamp, bit 5 standby release, bit 6 retention release; the clamps are active high); mem_pwr_o = 0; and branch_clk_en_o, core_clk_en_o, busy_o, done_o, error_o all 0.
- R2: A power_up seen while idle sets all three reset bits and busy_o in the next cycle, and clears error_o.
- R3: On the first tick after acceptance, branch_clk_en_o is set. Every later tick polls clk_off. The headswitch is set on the first poll that sees clk_off low, and only then.
- R4: If clk_off is high on POLL_MAX consecutive polls, error_o is set and busy_o is cleared on the last of those polls. The headswitch stays off and done_o does not pulse. A poll that sees clk_off low on exactly the POLL_MAX-th poll still succeeds.
- R5: On the ticks after the headswitch, these writes follow in turn: regulator bypass set, then memory clamp cleared, then standby release and retention release set.
- R6: With ORDER_MODE 0, one bank is enabled per tick, starting at bank NBANK-1 and going down to bank 0.
- R7: With ORDER_MODE 1, banks NBANK-1 down to SPLIT are enabled first, then banks 0 up to SPLIT-1, one per tick.
- R8: On the ticks after the last bank, these writes follow in turn: word-line clamp cleared, then IO clamp cleared, then core reset and stop released together, then core_clk_en_o set.
- R9: The bus reset bit stays asserted through the whole power-up sequence.
- R10: A power_down seen while idle clears core_clk_en_o in the next cycle. On the ticks that follow, these writes come in turn: IO clamp set, then all bank bits plus standby and retention release cleared, then core and bus reset set, then headswitch cleared.
- R11: busy_o is high from acceptance until completion. done_o pulses for exactly one cycle, with busy_o low, in the cycle where the final write of a sequence appears.
- R12: Requests that arrive while busy_o is high have no effect. If power_up and power_down arrive together while idle, power_up wins.
- R13: The power control word and the memory power word change only in the cycle after a cycle with us_tick high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_up | input | 1 | Start the power-up sequence (sampled when idle) |
| power_down | input | 1 | Start the power-down sequence (sampled when idle) |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| clk_off | input | 1 | Branch clock status, high while the clock is still off |
| rst_ctl_o | output | 3 | Reset group: stop, core reset, bus reset |
| pwr_ctl_o | output | 7 | Power control word |
| mem_pwr_o | output | NBANK | Per-bank memory power enables |
| branch_clk_en_o | output | 1 | Branch clock enable |
| core_clk_en_o | output | 1 | Core clock enable |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse when a sequence completes |
| error_o | output | 1 | Branch clock never came up; held until the next accepted request |

## Verification
The assertions assume that us_tick is a single-cycle pulse and that requests and clk_off are synchronous to clk. Under those assumptions, "changes only after a tick" and "stable while busy without a tick" are exact statements about the ports. The stimulus drives every input at the falling edge, keeps each tick high for one cycle, and places a random gap of zero to three idle cycles between ticks. Ignored requests, including power_up and power_down together, are injected only inside those gaps while busy_o is high. The poll count, the injections and the choice between up and down runs are randomized, and directed runs cover the exhausted poll limit and success on the final allowed poll.

// File: rtl/pss_pkg.sv
package pss_pkg;

    // Reset group bit positions
    localparam int RB_STOP = 0;
    localparam int RB_CORE = 1;
    localparam int RB_BUS  = 2;
    localparam int RST_W   = 3;

    // Power control word bit positions
    localparam int PB_HS      = 0;
    localparam int PB_BYP     = 1;
    localparam int PB_MCLAMP  = 2;
    localparam int PB_WLCLAMP = 3;
    localparam int PB_IOCLAMP = 4;
    localparam int PB_STBY    = 5;
    localparam int PB_RET     = 6;
    localparam int PWR_W      = 7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UP_RST,
        ST_UP_POLL,
        ST_UP_HS,
        ST_UP_BYP,
        ST_UP_MCLR,
        ST_UP_BANK,
        ST_UP_WL,
        ST_UP_IO,
        ST_UP_REL,
        ST_DN_CLK,
        ST_DN_IO,
        ST_DN_MEM,
        ST_DN_RST
    } seq_state_e;

endpackage

// File: rtl/pss_bank_order.sv
module pss_bank_order #(
    parameter int NBANK      = 20,
    parameter int SPLIT      = 6,
    parameter int ORDER_MODE = 0,
    localparam int BW        = $clog2(NBANK + 1)
) (
    input  logic [BW-1:0]    pos_i,
    output logic [NBANK-1:0] onehot_o
);

    int idx_w;

    generate
        if (ORDER_MODE == 0) begin : g_desc
            always_comb idx_w = NBANK - 1 - int'(pos_i);
        end else begin : g_split
            always_comb begin
                if (int'(pos_i) < NBANK - SPLIT) begin
                    idx_w = NBANK - 1 - int'(pos_i);
                end else begin
                    idx_w = int'(pos_i) - (NBANK - SPLIT);
                end
            end
        end
    endgenerate

    always_comb begin
        if (int'(pos_i) < NBANK) begin
            onehot_o = NBANK'(1) << idx_w;
        end else begin
            onehot_o = '0;
        end
    end

endmodule

// File: rtl/pss_poll_ctr.sv
module pss_poll_ctr #(
    parameter int LIMIT = 200,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    output logic last_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (step_i) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == CW'(LIMIT - 1));

    // R4: the sequencer never counts a poll past the limit
    a_r4_no_step_past_limit: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> !step_i);

endmodule

// File: rtl/pss_power_seq.sv
module pss_power_seq
    import pss_pkg::*;
#(
    parameter int NBANK      = 20,
    parameter int SPLIT      = 6,
    parameter int ORDER_MODE = 0,
    parameter int POLL_MAX   = 200,
    localparam int BW        = $clog2(NBANK + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             power_up,
    input  logic             power_down,
    input  logic             us_tick,
    input  logic             clk_off,
    output logic [RST_W-1:0] rst_ctl_o,
    output logic [PWR_W-1:0] pwr_ctl_o,
    output logic [NBANK-1:0] mem_pwr_o,
    output logic             branch_clk_en_o,
    output logic             core_clk_en_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             error_o
);

    localparam logic [PWR_W-1:0] PWR_RST =
        PWR_W'((1 << PB_MCLAMP) | (1 << PB_WLCLAMP) | (1 << PB_IOCLAMP));

    typedef struct packed {
        seq_state_e       st;
        logic [RST_W-1:0] rst;
        logic [PWR_W-1:0] pwr;
        logic [NBANK-1:0] mem;
        logic             bce;
        logic             cclk;
        logic [BW-1:0]    pos;
        logic             done;
        logic             err;
    } seq_t;

    seq_t s_d, s_q;

    logic             poll_clear, poll_step, poll_last;
    logic [NBANK-1:0] bank_sel;

    pss_bank_order #(
        .NBANK     (NBANK),
        .SPLIT     (SPLIT),
        .ORDER_MODE(ORDER_MODE)
    ) u_order (
        .pos_i   (s_q.pos),
        .onehot_o(bank_sel)
    );

    pss_poll_ctr #(
        .LIMIT(POLL_MAX)
    ) u_poll (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(poll_clear),
        .step_i (poll_step),
        .last_o (poll_last)
    );

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        poll_clear = 1'b0;
        poll_step  = 1'b0;

        if (s_q.st == ST_IDLE) begin
            if (power_up) begin
                s_d.rst = '1;
                s_d.err = 1'b0;
                s_d.st  = ST_UP_RST;
            end else if (power_down) begin
                s_d.cclk = 1'b0;
                s_d.err  = 1'b0;
                s_d.st   = ST_DN_CLK;
            end
        end else if (us_tick) begin
            unique case (s_q.st)
                ST_UP_RST: begin
                    s_d.bce    = 1'b1;
                    poll_clear = 1'b1;
                    s_d.st     = ST_UP_POLL;
                end
                ST_UP_POLL: begin
                    if (!clk_off) begin
                        s_d.pwr[PB_HS] = 1'b1;
                        s_d.st         = ST_UP_HS;
                    end else if (poll_last) begin
                        s_d.err = 1'b1;
                        s_d.st  = ST_IDLE;
                    end else begin
                        poll_step = 1'b1;
                    end
                end
                ST_UP_HS: begin
                    s_d.pwr[PB_BYP] = 1'b1;
                    s_d.st          = ST_UP_BYP;
                end
                ST_UP_BYP: begin
                    s_d.pwr[PB_MCLAMP] = 1'b0;
                    s_d.st             = ST_UP_MCLR;
                end
                ST_UP_MCLR: begin
                    s_d.pwr[PB_STBY] = 1'b1;
                    s_d.pwr[PB_RET]  = 1'b1;
                    s_d.pos          = '0;
                    s_d.st           = ST_UP_BANK;
                end
                ST_UP_BANK: begin
                    if (s_q.pos == BW'(NBANK)) begin
                        s_d.pwr[PB_WLCLAMP] = 1'b0;
                        s_d.st              = ST_UP_WL;
                    end else begin
                        s_d.mem = s_q.mem | bank_sel;
                        s_d.pos = s_q.pos + BW'(1);
                    end
                end
                ST_UP_WL: begin
                    s_d.pwr[PB_IOCLAMP] = 1'b0;
                    s_d.st              = ST_UP_IO;
                end
                ST_UP_IO: begin
                    s_d.rst[RB_CORE] = 1'b0;
                    s_d.rst[RB_STOP] = 1'b0;
                    s_d.st           = ST_UP_REL;
                end
                ST_UP_REL: begin
                    s_d.cclk = 1'b1;
                    s_d.done = 1'b1;
                    s_d.st   = ST_IDLE;
                end
                ST_DN_CLK: begin
                    s_d.pwr[PB_IOCLAMP] = 1'b1;
                    s_d.st              = ST_DN_IO;
                end
                ST_DN_IO: begin
                    s_d.mem          = '0;
                    s_d.pwr[PB_STBY] = 1'b0;
                    s_d.pwr[PB_RET]  = 1'b0;
                    s_d.st           = ST_DN_MEM;
                end
                ST_DN_MEM: begin
                    s_d.rst[RB_CORE] = 1'b1;
                    s_d.rst[RB_BUS]  = 1'b1;
                    s_d.st           = ST_DN_RST;
                end
                ST_DN_RST: begin
                    s_d.pwr[PB_HS] = 1'b0;
                    s_d.done       = 1'b1;
                    s_d.st         = ST_IDLE;
                end
                default: s_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st   <= ST_IDLE;
            s_q.rst  <= '1;
            s_q.pwr  <= PWR_RST;
            s_q.mem  <= '0;
            s_q.bce  <= 1'b0;
            s_q.cclk <= 1'b0;
            s_q.pos  <= '0;
            s_q.done <= 1'b0;
            s_q.err  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rst_ctl_o       = s_q.rst;
    assign pwr_ctl_o       = s_q.pwr;
    assign mem_pwr_o       = s_q.mem;
    assign branch_clk_en_o = s_q.bce;
    assign core_clk_en_o   = s_q.cclk;
    assign busy_o          = (s_q.st != ST_IDLE);
    assign done_o          = s_q.done;
    assign error_o         = s_q.err;

    // R2: an accepted power-up asserts every reset bit at once
    a_r2_up_resets: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && power_up) |=> (rst_ctl_o == '1) && busy_o && !error_o);

    // R3: the headswitch turns on only with the branch clock enabled and seen running
    a_r3_hs_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_ctl_o[PB_HS]) |-> branch_clk_en_o && !$past(clk_off));

    // R5: the bypass follows a headswitch that has been on for at least one cycle
    a_r5_byp_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_ctl_o[PB_BYP]) |-> pwr_ctl_o[PB_HS] && $past(pwr_ctl_o[PB_HS]));

    // R5: the wake bits follow the release of the memory clamp
    a_r5_ret_after_mclamp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_ctl_o[PB_RET]) |-> !pwr_ctl_o[PB_MCLAMP] && !$past(pwr_ctl_o[PB_MCLAMP]));

    // R6: banks are added one at a time
    a_r6_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mem_pwr_o) && (mem_pwr_o != '0))
            |-> $countones(mem_pwr_o) == $countones($past(mem_pwr_o)) + 1);

    // R8: the core leaves reset only with all clamps open and all banks on
    a_r8_release_order: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_ctl_o[RB_CORE]) |-> !pwr_ctl_o[PB_IOCLAMP] && !pwr_ctl_o[PB_WLCLAMP]
                                      && (mem_pwr_o == '1));

    // R8, R9: the clock starts after release, with the bus still held
    a_r9_bus_held: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_en_o) |-> !rst_ctl_o[RB_CORE] && !rst_ctl_o[RB_STOP]
                                 && rst_ctl_o[RB_BUS]);

    // R10: the headswitch goes off last
    a_r10_hs_off_last: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_ctl_o[PB_HS]) |-> rst_ctl_o[RB_CORE] && rst_ctl_o[RB_BUS]
                                    && pwr_ctl_o[PB_IOCLAMP] && (mem_pwr_o == '0)
                                    && !core_clk_en_o);

    // R11: done is a single-cycle pulse outside busy
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o ##1 !done_o);

    // R12: while busy nothing moves without a tick, whatever the requests
    a_r12_busy_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !us_tick) |=> $stable(rst_ctl_o) && $stable(pwr_ctl_o)
                                 && $stable(core_clk_en_o) && $stable(mem_pwr_o));

    // R13: the power and memory words change only after a tick
    a_r13_pwr_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pwr_ctl_o) |-> $past(us_tick));

    a_r13_mem_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_pwr_o) |-> $past(us_tick));

endmodule

// File: tb/sim_pss_power_seq.sv
module sim_pss_power_seq;

    localparam int NB = 20;
    localparam int SP = 6;
    localparam int PM = 200;

    // Bench's own view of the field positions (from the requirements)
    localparam int HS = 0, BYP = 1, MCL = 2, WCL = 3, IOC = 4, STB = 5, RET = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic power_up = 1'b0, power_down = 1'b0, us_tick = 1'b0, clk_off = 1'b0;

    logic [2:0]    rst0, rst1;
    logic [6:0]    pwr0, pwr1;
    logic [NB-1:0] mem0, mem1;
    logic bce0, bce1, cclk0, cclk1, busy0, busy1, done0, done1, err0, err1;

    int n_chk = 0;
    int n_fail = 0;

    logic [2:0]    e_rst;
    logic [6:0]    e_pwr;
    logic [NB-1:0] e_mem0, e_mem1;
    logic          e_bce, e_cclk;

    always #4 clk = ~clk;

    pss_power_seq #(.NBANK(NB), .SPLIT(SP), .ORDER_MODE(0), .POLL_MAX(PM)) u0 (
        .clk(clk), .rst_n(rst_n), .power_up(power_up), .power_down(power_down),
        .us_tick(us_tick), .clk_off(clk_off),
        .rst_ctl_o(rst0), .pwr_ctl_o(pwr0), .mem_pwr_o(mem0),
        .branch_clk_en_o(bce0), .core_clk_en_o(cclk0),
        .busy_o(busy0), .done_o(done0), .error_o(err0));

    pss_power_seq #(.NBANK(NB), .SPLIT(SP), .ORDER_MODE(1), .POLL_MAX(PM)) u1 (
        .clk(clk), .rst_n(rst_n), .power_up(power_up), .power_down(power_down),
        .us_tick(us_tick), .clk_off(clk_off),
        .rst_ctl_o(rst1), .pwr_ctl_o(pwr1), .mem_pwr_o(mem1),
        .branch_clk_en_o(bce1), .core_clk_en_o(cclk1),
        .busy_o(busy1), .done_o(done1), .error_o(err1));

    function automatic int bank_idx(input int mode, input int p);
        if (mode == 0)    return NB - 1 - p;
        if (p < NB - SP)  return NB - 1 - p;
        return p - (NB - SP);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk({req, " rst"}, 32'(rst0), 32'(e_rst));
        chk({req, " pwr"}, 32'(pwr0), 32'(e_pwr));
        chk({req, " mem mode0"}, 32'(mem0), 32'(e_mem0));
        chk({req, " mem mode1"}, 32'(mem1), 32'(e_mem1));
        chk({req, " bce"}, 32'(bce0), 32'(e_bce));
        chk({req, " cclk"}, 32'(cclk0), 32'(e_cclk));
        chk({req, " twin pwr"}, 32'(pwr1), 32'(e_pwr));
    endtask

    task automatic tick(input int gap, input bit inject);
        for (int j = 0; j < gap; j++) begin
            if (inject && j == 0) begin
                power_up   = 1'b1;
                power_down = 1'b1;
            end
            @(negedge clk);
            power_up   = 1'b0;
            power_down = 1'b0;
            if (inject && j == 0) begin
                chk("R12 request while busy, busy", 32'(busy0), 32'd1);
                check_all("R12 request while busy");
            end
        end
        us_tick = 1'b1;
        @(negedge clk);
        us_tick = 1'b0;
    endtask

    task automatic run_up(input int fails, input bit both, input bit rnd);
        power_up = 1'b1;
        power_down = both;
        @(negedge clk);
        power_up = 1'b0;
        power_down = 1'b0;
        e_rst = 3'b111;
        check_all("R2 accept up");
        chk("R2 busy", 32'(busy0), 32'd1);
        chk("R2 error cleared", 32'(err0), 32'd0);
        repeat (3) @(negedge clk);
        check_all("R13 no tick, no write");
        tick(rnd ? $urandom_range(0, 3) : 1, rnd);
        e_bce = 1'b1;
        check_all("R3 branch enable");
        for (int i = 0; i < fails; i++) begin
            clk_off = 1'b1;
            tick(rnd ? $urandom_range(0, 3) : 0, 1'b0);
            check_all("R3 poll still off");
            chk("R4 busy during polls", 32'(busy0), 32'd1);
        end
        clk_off = 1'b0;
        tick(rnd ? $urandom_range(0, 3) : 0, 1'b0);
        e_pwr[HS] = 1'b1;
        check_all("R3 headswitch on");
        chk("R4 no error", 32'(err0), 32'd0);
        tick(rnd ? $urandom_range(0, 3) : 0, rnd);
        e_pwr[BYP] = 1'b1;
        check_all("R5 bypass");
        tick(rnd ? $urandom_range(0, 3) : 0, 1'b0);
        e_pwr[MCL] = 1'b0;
        check_all("R5 memory clamp off");
        tick(rnd ? $urandom_range(0, 3) : 0, 1'b0);
        e_pwr[STB] = 1'b1;
        e_pwr[RET] = 1'b1;
        check_all("R5 wake bits");
        for (int p = 0; p < NB; p++) begin
            tick(rnd ? $urandom_range(0, 3) : 0, rnd && (p == 3));
            e_mem0[bank_idx(0, p)] = 1'b1;
            e_mem1[bank_idx(1, p)] = 1'b1;
            chk("R6 descending bank", 32'(mem0), 32'(e_mem0));
            chk("R7 split bank", 32'(mem1), 32'(e_mem1));
        end
        tick(rnd ? $urandom_range(0, 3) : 0, 1'b0);
        e_pwr[WCL] = 1'b0;
        check_all("R8 word-line clamp off");
        tick(rnd ? $urandom_range(0, 3) : 0, 1'b0);
        e_pwr[IOC] = 1'b0;
        check_all("R8 IO clamp off");
        tick(rnd ? $urandom_range(0, 3) : 0, 1'b0);
        e_rst = 3'b100;
        check_all("R8 core release");
        chk("R9 bus reset held", 32'(rst0[2]), 32'd1);
        tick(rnd ? $urandom_range(0, 3) : 0, rnd);
        e_cclk = 1'b1;
        check_all("R8 core clock");
        chk("R9 bus reset still held", 32'(rst0[2]), 32'd1);
        chk("R11 done pulse", 32'(done0), 32'd1);
        chk("R11 busy low at done", 32'(busy0), 32'd0);
        chk("R11 twin done", 32'(done1), 32'd1);
        @(negedge clk);
        chk("R11 done one cycle", 32'(done0), 32'd0);
    endtask

    task automatic run_dn(input bit rnd);
        power_down = 1'b1;
        @(negedge clk);
        power_down = 1'b0;
        e_cclk = 1'b0;
        check_all("R10 clock off");
        chk("R11 busy in down", 32'(busy0), 32'd1);
        tick(rnd ? $urandom_range(0, 3) : 1, rnd);
        e_pwr[IOC] = 1'b1;
        check_all("R10 IO clamp on");
        tick(rnd ? $urandom_range(0, 3) : 0, 1'b0);
        e_mem0 = '0;
        e_mem1 = '0;
        e_pwr[STB] = 1'b0;
        e_pwr[RET] = 1'b0;
        check_all("R10 memories off");
        tick(rnd ? $urandom_range(0, 3) : 0, rnd);
        e_rst = e_rst | 3'b110;
        check_all("R10 resets on");
        tick(rnd ? $urandom_range(0, 3) : 0, 1'b0);
        e_pwr[HS] = 1'b0;
        check_all("R10 headswitch off");
        chk("R11 done after down", 32'(done0), 32'd1);
        @(negedge clk);
        chk("R11 done one cycle after down", 32'(done0), 32'd0);
    endtask

    task automatic run_fail();
        power_up = 1'b1;
        @(negedge clk);
        power_up = 1'b0;
        e_rst = 3'b111;
        tick(1, 1'b0);
        e_bce = 1'b1;
        check_all("R3 branch enable before failing polls");
        clk_off = 1'b1;
        for (int i = 0; i < PM - 1; i++) begin
            tick(i % 3, 1'b0);
        end
        chk("R4 busy before last poll", 32'(busy0), 32'd1);
        chk("R4 no error before last poll", 32'(err0), 32'd0);
        tick(1, 1'b0);
        chk("R4 error at limit", 32'(err0), 32'd1);
        chk("R4 busy cleared", 32'(busy0), 32'd0);
        chk("R4 no done", 32'(done0), 32'd0);
        check_all("R4 headswitch stays off");
        clk_off = 1'b0;
        repeat (2) @(negedge clk);
        chk("R4 error held", 32'(err0), 32'd1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        e_rst  = 3'b111;
        e_pwr  = 7'h1C;
        e_mem0 = '0;
        e_mem1 = '0;
        e_bce  = 1'b0;
        e_cclk = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset state");
        chk("R1 busy", 32'(busy0), 32'd0);
        chk("R1 done", 32'(done0), 32'd0);
        chk("R1 error", 32'(err0), 32'd0);

        run_up(0, 1'b0, 1'b0);
        run_dn(1'b0);
        run_fail();
        run_up(PM - 1, 1'b0, 1'b0);
        run_up(2, 1'b1, 1'b0);
        chk("R12 up wins over down", 32'(cclk0), 32'd1);
        run_dn(1'b1);
        for (int it = 0; it < 10; it++) begin
            if ($urandom_range(0, 1) == 0) run_up($urandom_range(0, 5), 1'b0, 1'b1);
            else                           run_dn(1'b1);
        end
        run_dn(1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule